// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs the entry half of trap handling for a processor core with machine, supervisor and user privilege levels. When an exception or interrupt is presented for one cycle, the block decides whether supervisor or machine software handles it. It records the cause, the interrupted PC and, where it applies, the offending address in that level's registers. It also rewrites the interrupt-enable stack in the status word, computes the handler address and switches privilege. All of this finishes on the clock edge that accepts the request.

The surrounding core supplies the current privilege, the status word, both delegation masks and both vector-base registers as inputs. The block returns the updated status word, the six trap registers (cause, exception PC and trap value for each handling level), the handler PC and the new privilege. It also keeps the load-reservation flag for the core, because every trap entry has to drop it.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is asserted, new_priv is 2'b11 (machine), trap_taken and resv_valid are 0, and status_out, new_pc and all six trap registers are 0.
- R2: Privilege encoding is user 2'b00, supervisor 2'b01, machine 2'b11. A trap goes to supervisor only if cur_priv is user or supervisor and bit[code] of the delegation mask is 1. The mask is mideleg for an interrupt and medeleg for an exception, and for an environment call the code used is the remapped one. Every other trap goes to machine.
- R3: On supervisor entry, status_out equals status_in with bit 5 taking the old bit 1, bit 8 taking cur_priv[0], and bit 1 cleared.
- R4: On machine entry, status_out equals status_in with bit 7 taking the old bit 3, bits 12:11 taking cur_priv, and bit 3 cleared.
- R5: The cause register of the chosen level receives the 5-bit code in bits 4:0, zeros above it, and bit 31 set exactly when the trap is an interrupt.
- R6: The exception PC register of the chosen level receives pc_in. The cause, PC and value registers of the other level keep their values.
- R7: For exceptions with codes 0, 1, 4, 5, 6, 7, 12, 13 or 15, the chosen trap value register receives fault_addr. For all other exceptions and for all interrupts it receives 0.
- R8: new_pc is the chosen level's vector base with bits 1:0 cleared. If the trap is an interrupt and the base's bits 1:0 equal 2'b01, code×4 is added. Any other mode value, and every exception, adds nothing.
- R9: An exception with code 8 (environment call) is recorded as 8 from user, 9 from supervisor and 11 from machine. An interrupt with code 8 is not remapped.
- R10: resv_set makes resv_valid 1 on the next edge. Any trap entry makes it 0, including one in the same cycle as resv_set.
- R11: trap_taken is 1 for exactly the cycle after an accepted request. Without a request, new_priv, new_pc, status_out and all trap registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap event this cycle |
| is_irq | input | 1 | 1 = interrupt, 0 = exception |
| code | input | 5 | Cause code of the event |
| pc_in | input | 32 | PC of the interrupted instruction |
| fault_addr | input | 32 | Offending address for address-bearing faults |
| cur_priv | input | 2 | Current privilege level |
| status_in | input | 32 | Current status word |
| medeleg | input | 32 | Exception delegation mask |
| mideleg | input | 32 | Interrupt delegation mask |
| stvec | input | 32 | Supervisor vector base and mode |
| mtvec | input | 32 | Machine vector base and mode |
| resv_set | input | 1 | Load-reserved executed: set reservation |
| trap_taken | output | 1 | Trap entry happened on the last edge |
| new_priv | output | 2 | Privilege after entry |
| new_pc | output | 32 | Handler address |
| status_out | output | 32 | Updated status word |
| scause | output | 32 | Supervisor cause register |
| sepc | output | 32 | Supervisor exception PC |
| stval | output | 32 | Supervisor trap value |
| mcause | output | 32 | Machine cause register |
| mepc | output | 32 | Machine exception PC |
| mtval | output | 32 | Machine trap value |
| resv_valid | output | 1 | Load reservation held |

## Verification
A trap entry and a new load reservation can land on the same edge. The bench raises resv_set in the same cycle as a trap request and expects resv_valid to read 0 afterwards. It then raises resv_set alone and expects 1. In the same way, an environment call's remapped code also decides delegation. The bench therefore gives a supervisor-level call a mask with only bit 8 set, expects machine entry with cause 9, and then repeats the call with bit 9 set and expects supervisor entry.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_USR = 2'b00,
    PRIV_SUP = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_MCH = 2'b11
  } priv_e;

  // status word bit positions decoded by neighbouring CSR logic
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  localparam int ENV_CALL_CODE = 8;
  // exception codes that carry an address in the trap value register
  localparam logic [31:0] ADDR_CAUSE_MASK = 32'h0000_B0F3;
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        cur_priv,
  input  logic [XLEN-1:0]   medeleg,
  input  logic [XLEN-1:0]   mideleg,
  input  logic [XLEN-1:0]   fault_addr,
  output logic [CODE_W-1:0] eff_code,
  output logic              to_super,
  output logic [XLEN-1:0]   tval
);
  localparam logic [CODE_W-1:0] ECALL = CODE_W'(ENV_CALL_CODE);

  logic [XLEN-1:0] deleg_mask;
  logic            is_ecall;
  logic            addr_cause;

  always_comb begin
    is_ecall   = !is_irq && (code == ECALL);
    eff_code   = is_ecall ? (ECALL + CODE_W'(cur_priv)) : code;
    deleg_mask = is_irq ? mideleg : medeleg;
    to_super   = (cur_priv <= PRIV_SUP) && deleg_mask[eff_code];
    addr_cause = !is_irq && ADDR_CAUSE_MASK[eff_code];
    tval       = addr_cause ? fault_addr : '0;
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic [XLEN-1:0]   tvec,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   handler
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base    = {tvec[XLEN-1:2], 2'b00};
    offset  = (is_irq && tvec[1:0] == 2'b01) ? (XLEN'(code) << 2) : '0;
    handler = base + offset;
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic [1:0]        cur_priv,
  input  logic [XLEN-1:0]   status_in,
  input  logic [XLEN-1:0]   medeleg,
  input  logic [XLEN-1:0]   mideleg,
  input  logic [XLEN-1:0]   stvec,
  input  logic [XLEN-1:0]   mtvec,
  input  logic              resv_set,
  output logic              trap_taken,
  output logic [1:0]        new_priv,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   status_out,
  output logic [XLEN-1:0]   scause,
  output logic [XLEN-1:0]   sepc,
  output logic [XLEN-1:0]   stval,
  output logic [XLEN-1:0]   mcause,
  output logic [XLEN-1:0]   mepc,
  output logic [XLEN-1:0]   mtval,
  output logic              resv_valid
);
  localparam int NLVL  = 2;
  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic [CODE_W-1:0] eff_code;
  logic              to_super;
  logic [XLEN-1:0]   tval_sel;
  logic [XLEN-1:0]   handler [NLVL];
  logic [XLEN-1:0]   tvec_lvl [NLVL];

  trap_route #(.XLEN(XLEN), .CODE_W(CODE_W)) u_route (
    .is_irq    (is_irq),
    .code      (code),
    .cur_priv  (cur_priv),
    .medeleg   (medeleg),
    .mideleg   (mideleg),
    .fault_addr(fault_addr),
    .eff_code  (eff_code),
    .to_super  (to_super),
    .tval      (tval_sel)
  );

  assign tvec_lvl[0] = stvec;
  assign tvec_lvl[1] = mtvec;

  for (genvar g = 0; g < NLVL; g++) begin : g_vec
    trap_vector #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
      .tvec   (tvec_lvl[g]),
      .is_irq (is_irq),
      .code   (eff_code),
      .handler(handler[g])
    );
  end

  // next-state values
  logic [XLEN-1:0] status_d;
  logic [XLEN-1:0] cause_d;
  logic [XLEN-1:0] pc_d;
  logic [1:0]      priv_d;
  logic            resv_d;

  always_comb begin
    status_d = status_in;
    if (to_super) begin
      status_d[ST_SPIE] = status_in[ST_SIE];
      status_d[ST_SPP]  = cur_priv[0];
      status_d[ST_SIE]  = 1'b0;
      priv_d            = PRIV_SUP;
      pc_d              = handler[0];
    end else begin
      status_d[ST_MPIE]        = status_in[ST_MIE];
      status_d[ST_MPP +: 2]    = cur_priv;
      status_d[ST_MIE]         = 1'b0;
      priv_d                   = PRIV_MCH;
      pc_d                     = handler[1];
    end
    cause_d = {is_irq, {PAD_W{1'b0}}, eff_code};
    resv_d  = trap_req ? 1'b0 : (resv_set ? 1'b1 : resv_valid);
  end

  logic s_en, m_en;
  assign s_en = trap_req && to_super;
  assign m_en = trap_req && !to_super;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_taken <= 1'b0;
      new_priv   <= PRIV_MCH;
      new_pc     <= '0;
      status_out <= '0;
      resv_valid <= 1'b0;
    end else begin
      trap_taken <= trap_req;
      resv_valid <= resv_d;
      if (trap_req) begin
        new_priv   <= priv_d;
        new_pc     <= pc_d;
        status_out <= status_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scause <= '0;
      sepc   <= '0;
      stval  <= '0;
    end else if (s_en) begin
      scause <= cause_d;
      sepc   <= pc_in;
      stval  <= tval_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcause <= '0;
      mepc   <= '0;
      mtval  <= '0;
    end else if (m_en) begin
      mcause <= cause_d;
      mepc   <= pc_in;
      mtval  <= tval_sel;
    end
  end

  // R2
  m_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && cur_priv == PRIV_MCH |=> new_priv == PRIV_MCH);

  // R4
  mie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && cur_priv == PRIV_MCH |=> !status_out[ST_MIE]);

  // R6
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && cur_priv == PRIV_MCH |=> mepc == $past(pc_in));

  // R10
  resv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !resv_valid);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> $stable(mepc) && $stable(sepc) && $stable(new_priv) && !trap_taken);
endmodule

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_req, is_irq, resv_set;
  logic [4:0]  code;
  logic [31:0] pc_in, fault_addr, status_in, medeleg, mideleg, stvec, mtvec;
  logic [1:0]  cur_priv;
  logic        trap_taken, resv_valid;
  logic [1:0]  new_priv;
  logic [31:0] new_pc, status_out, scause, sepc, stval, mcause, mepc, mtval;

  always #2.5 clk = ~clk;

  trap_entry_unit u_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .is_irq(is_irq), .code(code),
    .pc_in(pc_in), .fault_addr(fault_addr), .cur_priv(cur_priv), .status_in(status_in),
    .medeleg(medeleg), .mideleg(mideleg), .stvec(stvec), .mtvec(mtvec),
    .resv_set(resv_set), .trap_taken(trap_taken), .new_priv(new_priv), .new_pc(new_pc),
    .status_out(status_out), .scause(scause), .sepc(sepc), .stval(stval),
    .mcause(mcause), .mepc(mepc), .mtval(mtval), .resv_valid(resv_valid)
  );

  typedef struct packed {
    logic        irq;
    logic [4:0]  code;
    logic [1:0]  priv;
    logic [31:0] status;
    logic [31:0] medeleg;
    logic [31:0] mideleg;
    logic [31:0] mtvec;
    logic        exp_s;
    logic [31:0] exp_cause;
    logic [31:0] exp_pc;
    logic [31:0] exp_status;
    logic        has_tval;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd2,  2'd0, 32'h2,         32'h4,         32'h0,         32'h3001, 1'b1, 32'h2,         32'h2000, 32'h20,        1'b0},
    '{1'b0, 5'd13, 2'd1, 32'h0004_0000, 32'h2000,      32'h0,         32'h3001, 1'b1, 32'd13,        32'h2000, 32'h0004_0100, 1'b1},
    '{1'b0, 5'd13, 2'd3, 32'h8,         32'h2000,      32'h0,         32'h3001, 1'b0, 32'd13,        32'h3000, 32'h1880,      1'b1},
    '{1'b1, 5'd5,  2'd0, 32'h2,         32'h0,         32'h20,        32'h3001, 1'b1, 32'h8000_0005, 32'h2014, 32'h20,        1'b0},
    '{1'b1, 5'd7,  2'd1, 32'hA,         32'h0,         32'h0,         32'h3001, 1'b0, 32'h8000_0007, 32'h301C, 32'h882,       1'b0},
    '{1'b1, 5'd7,  2'd3, 32'h0,         32'h0,         32'h0,         32'h3002, 1'b0, 32'h8000_0007, 32'h3000, 32'h1800,      1'b0},
    '{1'b0, 5'd8,  2'd0, 32'h0,         32'h100,       32'h0,         32'h3001, 1'b1, 32'd8,         32'h2000, 32'h0,         1'b0},
    '{1'b0, 5'd8,  2'd1, 32'h0,         32'h100,       32'h0,         32'h3001, 1'b0, 32'd9,         32'h3000, 32'h800,       1'b0},
    '{1'b0, 5'd8,  2'd1, 32'h0,         32'h200,       32'h0,         32'h3001, 1'b1, 32'd9,         32'h2000, 32'h100,       1'b0},
    '{1'b0, 5'd8,  2'd3, 32'h0,         32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h3001, 1'b0, 32'd11,        32'h3000, 32'h1800,      1'b0},
    '{1'b1, 5'd8,  2'd0, 32'h0,         32'h0,         32'h0,         32'h3001, 1'b0, 32'h8000_0008, 32'h3020, 32'h0,         1'b0},
    '{1'b0, 5'd0,  2'd0, 32'h0,         32'h0,         32'h0,         32'h3001, 1'b0, 32'd0,         32'h3000, 32'h0,         1'b1},
    '{1'b0, 5'd3,  2'd0, 32'h0,         32'h0,         32'h0,         32'h3001, 1'b0, 32'd3,         32'h3000, 32'h0,         1'b0},
    '{1'b1, 5'd5,  2'd0, 32'h0,         32'h20,        32'h0,         32'h3001, 1'b0, 32'h8000_0005, 32'h3014, 32'h0,         1'b0},
    '{1'b0, 5'd5,  2'd0, 32'h0,         32'h20,        32'h0,         32'h3001, 1'b1, 32'd5,         32'h2000, 32'h0,         1'b1}
  };

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [31:0] m_sc, m_se, m_st, m_mc, m_me, m_mt;

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trap_req = 0; is_irq = 0; resv_set = 0; code = '0;
    pc_in = '0; fault_addr = '0; status_in = '0; medeleg = '0; mideleg = '0;
    stvec = 32'h2001; mtvec = 32'h3001; cur_priv = 2'd3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "new_priv", {30'd0, new_priv}, 32'd3);
    chk("R1", "trap_taken", {31'd0, trap_taken}, 32'd0);
    chk("R1", "resv_valid", {31'd0, resv_valid}, 32'd0);
    chk("R1", "status_out", status_out, 32'd0);
    chk("R1", "new_pc", new_pc, 32'd0);
    chk("R1", "mcause|scause|mepc|sepc|mtval|stval",
        mcause | scause | mepc | sepc | mtval | stval, 32'd0);
    rst_n = 1'b1;
    m_sc = 0; m_se = 0; m_st = 0; m_mc = 0; m_me = 0; m_mt = 0;

    // table walk: R2..R9 and R6 through a register model
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      is_irq = VECS[i].irq; code = VECS[i].code; cur_priv = VECS[i].priv;
      status_in = VECS[i].status; medeleg = VECS[i].medeleg;
      mideleg = VECS[i].mideleg; mtvec = VECS[i].mtvec;
      pc_in = 32'h1000_0000 | (i << 4); fault_addr = 32'hDEAD_0000 | i;
      trap_req = 1'b1;
      @(negedge clk);
      trap_req = 1'b0;
      if (VECS[i].exp_s) begin
        m_sc = VECS[i].exp_cause; m_se = pc_in;
        m_st = VECS[i].has_tval ? fault_addr : 32'd0;
      end else begin
        m_mc = VECS[i].exp_cause; m_me = pc_in;
        m_mt = VECS[i].has_tval ? fault_addr : 32'd0;
      end
      chk("R2", "new_priv", {30'd0, new_priv}, VECS[i].exp_s ? 32'd1 : 32'd3);
      chk("R3/R4", "status_out", status_out, VECS[i].exp_status);
      chk("R8", "new_pc", new_pc, VECS[i].exp_pc);
      chk("R5/R9", "scause", scause, m_sc);
      chk("R5/R9", "mcause", mcause, m_mc);
      chk("R6", "sepc", sepc, m_se);
      chk("R6", "mepc", mepc, m_me);
      chk("R7", "stval", stval, m_st);
      chk("R7", "mtval", mtval, m_mt);
      chk("R11", "trap_taken", {31'd0, trap_taken}, 32'd1);
    end

    // R11 idle cycle: pulse ends, everything holds despite changed inputs
    pc_in = 32'h5555_0000; status_in = 32'hFFFF_FFFF; cur_priv = 2'd0;
    @(negedge clk);
    chk("R11", "trap_taken idle", {31'd0, trap_taken}, 32'd0);
    chk("R11", "new_pc hold", new_pc, 32'h2000);
    chk("R11", "status hold", status_out, 32'h0);
    chk("R11", "mepc hold", mepc, m_me);
    chk("R11", "new_priv hold", {30'd0, new_priv}, 32'd1);

    // R10 reservation set, then same-cycle trap and set
    resv_set = 1'b1;
    @(negedge clk);
    resv_set = 1'b0;
    chk("R10", "resv after set", {31'd0, resv_valid}, 32'd1);
    @(negedge clk);
    chk("R10", "resv held", {31'd0, resv_valid}, 32'd1);
    resv_set = 1'b1; trap_req = 1'b1; is_irq = 0; code = 5'd2;
    medeleg = 0; mtvec = 32'h3001; cur_priv = 2'd0;
    @(negedge clk);
    resv_set = 1'b0; trap_req = 1'b0;
    chk("R10", "resv trap wins", {31'd0, resv_valid}, 32'd0);
    resv_set = 1'b1;
    @(negedge clk);
    resv_set = 1'b0;
    chk("R10", "resv set again", {31'd0, resv_valid}, 32'd1);

    // R1 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "priv on reset", {30'd0, new_priv}, 32'd3);
    chk("R1", "resv on reset", {31'd0, resv_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule